// File: doc/BRIEF.md
# Bus Access Address Error Checker

This block sits in front of the bus interface and judges each access request before the bus cycle starts. It looks at the cycle type, the requesting master, the access size, the 32-bit address and three qualifier flags: PC-relative addressing, test-and-set instruction and memory mode-register write. From these it decides whether the access is an address error. The checks cover alignment for fetches and data and the instruction-type and addressing-mode limits on special memory spaces. They also cover the size rules that differ between windows of the peripheral register space.

A request is offered with `req_valid` for one cycle. The checker always accepts it and never applies back-pressure, so it has no ready signal. The verdict appears one clock later as a single-cycle `fault_pulse`. The first faulting access is copied into holding registers (address, size, master, cycle type) for an exception unit. That copy stays until `hold_clr` is pulsed. The cache-purge, address-array, data-array and mode-setting spaces are set by base/mask parameters. The peripheral space is a parameterised 64 KiB window, by default 0xFFFF0000 to 0xFFFFFFFF. A 16-byte DMA block is presented as a series of longword requests and is checked as such.

Top module: `bus_addr_fault_chk`

## Requirements
- R1: An instruction fetch (`cyc_fetch`=1) from an odd address faults; a fetch from an even address outside the peripheral space does not.
- R2: Any instruction fetch whose address is in the peripheral space (0xFFFF0000–0xFFFFFFFF) faults.
- R3: A data access faults if it is a word (`acc_size`=1) at an odd address, a longword (`acc_size`=2) with address bits [1:0] not 00, or uses the reserved size code 3. These rules apply alike for `bus_master` 0 (CPU), 1 (DMA) and 2 (Ethernet DMA).
- R4: A PC-relative data access faults when it targets the cache-purge, address-array, peripheral or mode-setting space. A PC-relative access to the data-array space is legal.
- R5: A test-and-set data access faults when it targets the cache-purge, address-array, data-array, peripheral or mode-setting space.
- R6: Inside the peripheral space, offsets 0xF100–0xFDFF (including 0xFC00–0xFCFF) accept byte, word and longword data accesses.
- R7: Peripheral offsets 0xFE00–0xFEFF reject longword data accesses and accept byte and word.
- R8: Peripheral offsets 0x0000–0xF0FF and 0xFF00–0xFFFF reject byte data accesses (`acc_size`=0) and accept word and longword.
- R9: While `mode_wr` is high no fault is raised, whatever the address, size or flags.
- R10: `fault_pulse` is high for exactly the one cycle after a clock edge at which `req_valid` was high and the request broke a rule; it never rises without `req_valid`.
- R11: On a fault with the holding registers empty (or cleared in the same cycle), the address, size, master and cycle type are captured and `hold_valid` is set. Later faults do not overwrite the captured values, and `hold_clr` empties the registers.
- R12: After reset, `fault_pulse` and `hold_valid` are low and the held fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data read/write |
| bus_master | input | 2 | 0 CPU, 1 DMA, 2 Ethernet DMA |
| acc_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| acc_addr | input | 32 | Access address |
| pc_rel | input | 1 | Access uses PC-relative addressing |
| tas_op | input | 1 | Access belongs to a test-and-set instruction |
| mode_wr | input | 1 | Memory mode-register write cycle |
| hold_clr | input | 1 | Empties the fault holding registers |
| fault_pulse | output | 1 | One-cycle address-error pulse |
| hold_valid | output | 1 | Holding registers contain a fault |
| hold_addr | output | 32 | Captured faulting address |
| hold_size | output | 2 | Captured access size |
| hold_master | output | 2 | Captured bus master |
| hold_fetch | output | 1 | Captured cycle type |

## Verification
Assertions check several properties on every cycle: odd fetches and misaligned longwords raise the pulse, mode-register writes stay silent, the pulse never appears without a request, and a held fault stays unchanged until cleared. The bench's scenarios are needed for the rest. These are the region windows in the peripheral space and the different space lists for PC-relative and test-and-set accesses. They also include the effect of the base/mask parameters and the ordering of capture against a clear arriving in the same cycle as a new fault.

// File: rtl/bafc_pkg.sv
package bafc_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} acc_size_e;
  typedef enum logic [1:0] {MST_CPU = 2'd0, MST_DMA = 2'd1, MST_EDMA = 2'd2, MST_RSVD = 2'd3} bus_master_e;

  typedef struct packed {
    logic periph;
    logic p_nolong;
    logic p_nobyte;
    logic purge;
    logic aarr;
    logic darr;
    logic mset;
  } space_hits_t;
endpackage

// File: rtl/bafc_space_dec.sv
module bafc_space_dec
  import bafc_pkg::*;
#(
  parameter int          AW           = 32,
  parameter logic [31:0] PURGE_BASE   = 32'h4000_0000,
  parameter logic [31:0] PURGE_MASK   = 32'hE000_0000,
  parameter logic [31:0] AARR_BASE    = 32'h6000_0000,
  parameter logic [31:0] AARR_MASK    = 32'hE000_0000,
  parameter logic [31:0] DARR_BASE    = 32'hC000_0000,
  parameter logic [31:0] DARR_MASK    = 32'hF000_0000,
  parameter logic [31:0] MSET_BASE    = 32'hFFFE_0000,
  parameter logic [31:0] MSET_MASK    = 32'hFFFF_0000,
  parameter logic [31:0] PERIPH_BASE  = 32'hFFFF_0000,
  parameter int          PG_LSB       = 8,
  parameter logic [7:0]  NOLONG_PAGE  = 8'hFE,
  parameter logic [7:0]  LOBYTE_LAST  = 8'hF0,
  parameter logic [7:0]  HIBYTE_PAGE  = 8'hFF
) (
  input  logic [AW-1:0] addr,
  output space_hits_t   hits
);
  localparam int NWIN   = 4;
  localparam int PG_MSB = PG_LSB + 7;
  localparam int OFF_W  = PG_MSB + 1;
  localparam logic [AW-1:0] PERIPH_MASK = {{(AW-OFF_W){1'b1}}, {OFF_W{1'b0}}};
  localparam logic [AW-1:0] WBASE [NWIN] = '{PURGE_BASE, AARR_BASE, DARR_BASE, MSET_BASE};
  localparam logic [AW-1:0] WMASK [NWIN] = '{PURGE_MASK, AARR_MASK, DARR_MASK, MSET_MASK};

  logic [NWIN-1:0] win;
  logic            in_periph;
  logic [7:0]      page;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign win[i] = ((addr ^ WBASE[i]) & WMASK[i]) == '0;
  end

  assign in_periph = ((addr ^ PERIPH_BASE) & PERIPH_MASK) == '0;
  assign page      = addr[PG_MSB:PG_LSB];

  always_comb begin
    hits          = '0;
    hits.purge    = win[0];
    hits.aarr     = win[1];
    hits.darr     = win[2];
    hits.mset     = win[3];
    hits.periph   = in_periph;
    hits.p_nolong = in_periph && (page == NOLONG_PAGE);
    hits.p_nobyte = in_periph && ((page <= LOBYTE_LAST) || (page == HIBYTE_PAGE));
  end

  always_comb begin
    assert (!(hits.p_nolong && hits.p_nobyte)) else $error("AST_WINDOWS_DISJOINT"); // R7 R8
  end
endmodule

// File: rtl/bafc_rule_eval.sv
module bafc_rule_eval
  import bafc_pkg::*;
(
  input  space_hits_t hits,
  input  logic        is_fetch,
  input  acc_size_e   size,
  input  logic [1:0]  a_lo,
  input  logic        pc_rel,
  input  logic        tas_op,
  input  logic        mode_wr,
  output logic        viol
);
  logic fetch_bad, align_bad, pcrel_bad, tas_bad, region_bad;

  always_comb begin
    fetch_bad  = is_fetch && (a_lo[0] || hits.periph);
    align_bad  = 1'b0;
    region_bad = 1'b0;
    unique case (size)
      SZ_BYTE: region_bad = hits.p_nobyte;
      SZ_WORD: align_bad  = a_lo[0];
      SZ_LONG: begin
        align_bad  = a_lo != 2'b00;
        region_bad = hits.p_nolong;
      end
      default: align_bad = 1'b1;
    endcase
    pcrel_bad = pc_rel && (hits.purge || hits.aarr || hits.periph || hits.mset);
    tas_bad   = tas_op && (hits.purge || hits.aarr || hits.darr || hits.periph || hits.mset);
    if (mode_wr)       viol = 1'b0;
    else if (is_fetch) viol = fetch_bad;
    else               viol = align_bad || region_bad || pcrel_bad || tas_bad;
  end
endmodule

// File: rtl/bafc_fault_hold.sv
module bafc_fault_hold
  import bafc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [1:0]    master,
  input  logic          is_fetch,
  output logic          hold_valid,
  output logic [AW-1:0] hold_addr,
  output logic [1:0]    hold_size,
  output logic [1:0]    hold_master,
  output logic          hold_fetch
);
  logic take;
  assign take = fault && (!hold_valid || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid  <= 1'b0;
      hold_addr   <= '0;
      hold_size   <= '0;
      hold_master <= '0;
      hold_fetch  <= 1'b0;
    end else begin
      if (take) begin
        hold_addr   <= addr;
        hold_size   <= size;
        hold_master <= master;
        hold_fetch  <= is_fetch;
      end
      hold_valid <= fault || (hold_valid && !clr);
    end
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid && !clr |=> hold_valid && $stable(hold_addr) && $stable(hold_size)) // R11
    else $error("AST_HOLD_KEEPS");
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !fault |=> !hold_valid) // R11
    else $error("AST_CLR_EMPTIES");
endmodule

// File: rtl/bus_addr_fault_chk.sv
module bus_addr_fault_chk
  import bafc_pkg::*;
#(
  parameter int          AW          = 32,
  parameter logic [31:0] PURGE_BASE  = 32'h4000_0000,
  parameter logic [31:0] PURGE_MASK  = 32'hE000_0000,
  parameter logic [31:0] AARR_BASE   = 32'h6000_0000,
  parameter logic [31:0] AARR_MASK   = 32'hE000_0000,
  parameter logic [31:0] DARR_BASE   = 32'hC000_0000,
  parameter logic [31:0] DARR_MASK   = 32'hF000_0000,
  parameter logic [31:0] MSET_BASE   = 32'hFFFE_0000,
  parameter logic [31:0] MSET_MASK   = 32'hFFFF_0000,
  parameter logic [31:0] PERIPH_BASE = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          cyc_fetch,
  input  logic [1:0]    bus_master,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] acc_addr,
  input  logic          pc_rel,
  input  logic          tas_op,
  input  logic          mode_wr,
  input  logic          hold_clr,
  output logic          fault_pulse,
  output logic          hold_valid,
  output logic [AW-1:0] hold_addr,
  output logic [1:0]    hold_size,
  output logic [1:0]    hold_master,
  output logic          hold_fetch
);
  space_hits_t hits;
  logic        viol;
  logic        fault_now;

  bafc_space_dec #(
    .AW(AW), .PURGE_BASE(PURGE_BASE), .PURGE_MASK(PURGE_MASK),
    .AARR_BASE(AARR_BASE), .AARR_MASK(AARR_MASK),
    .DARR_BASE(DARR_BASE), .DARR_MASK(DARR_MASK),
    .MSET_BASE(MSET_BASE), .MSET_MASK(MSET_MASK),
    .PERIPH_BASE(PERIPH_BASE)
  ) u_dec (
    .addr (acc_addr),
    .hits (hits)
  );

  bafc_rule_eval u_rules (
    .hits     (hits),
    .is_fetch (cyc_fetch),
    .size     (acc_size_e'(acc_size)),
    .a_lo     (acc_addr[1:0]),
    .pc_rel   (pc_rel),
    .tas_op   (tas_op),
    .mode_wr  (mode_wr),
    .viol     (viol)
  );

  assign fault_now = req_valid && viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_pulse <= 1'b0;
    else        fault_pulse <= fault_now;
  end

  bafc_fault_hold #(.AW(AW)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault       (fault_now),
    .clr         (hold_clr),
    .addr        (acc_addr),
    .size        (acc_size),
    .master      (bus_master),
    .is_fetch    (cyc_fetch),
    .hold_valid  (hold_valid),
    .hold_addr   (hold_addr),
    .hold_size   (hold_size),
    .hold_master (hold_master),
    .hold_fetch  (hold_fetch)
  );

  AST_FETCH_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cyc_fetch && acc_addr[0] && !mode_wr |=> fault_pulse) // R1
    else $error("AST_FETCH_ODD");
  AST_LONG_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !cyc_fetch && acc_size == 2'd2 && acc_addr[1:0] != 2'b00 && !mode_wr |=> fault_pulse) // R3
    else $error("AST_LONG_MISALIGN");
  AST_MODE_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !fault_pulse) // R9
    else $error("AST_MODE_WR_SILENT");
  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> $past(req_valid)) // R10
    else $error("AST_PULSE_NEEDS_REQ");
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> hold_valid) // R11
    else $error("AST_PULSE_HELD");
endmodule

// File: tb/sim_bus_addr_fault_chk.sv
`timescale 1ns/1ps
module sim_bus_addr_fault_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, cyc_fetch = 0, pc_rel = 0, tas_op = 0, mode_wr = 0, hold_clr = 0;
  logic [1:0]  bus_master = 0, acc_size = 0;
  logic [31:0] acc_addr = 0;
  logic        fault_pulse, hold_valid, hold_fetch;
  logic [31:0] hold_addr;
  logic [1:0]  hold_size, hold_master;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit        e_pulse = 0, e_hv = 0, e_hf = 0;
  bit [31:0] e_ha = 0;
  bit [1:0]  e_hs = 0, e_hm = 0;

  always #2 clk = ~clk;

  bus_addr_fault_chk u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cyc_fetch(cyc_fetch),
    .bus_master(bus_master), .acc_size(acc_size), .acc_addr(acc_addr),
    .pc_rel(pc_rel), .tas_op(tas_op), .mode_wr(mode_wr), .hold_clr(hold_clr),
    .fault_pulse(fault_pulse), .hold_valid(hold_valid), .hold_addr(hold_addr),
    .hold_size(hold_size), .hold_master(hold_master), .hold_fetch(hold_fetch)
  );

  function automatic bit ref_err(bit f, int sz, bit [31:0] a, bit pr, bit ts, bit mw);
    bit per   = a >= 32'hFFFF_0000;
    bit purge = a[31:29] == 3'b010;
    bit aarr  = a[31:29] == 3'b011;
    bit darr  = a[31:28] == 4'hC;
    bit mset  = a[31:16] == 16'hFFFE;
    int off   = int'(a[15:0]);
    if (mw) return 0;
    if (f) return a[0] || per;
    if (sz == 3) return 1;
    if (sz == 1 && a[0]) return 1;
    if (sz == 2 && a[1:0] != 0) return 1;
    if (pr && (purge || aarr || per || mset)) return 1;
    if (ts && (purge || aarr || darr || per || mset)) return 1;
    if (per) begin
      if (sz == 2 && off >= 'hFE00 && off <= 'hFEFF) return 1;
      if (sz == 0 && (off <= 'hF0FF || off >= 'hFF00)) return 1;
    end
    return 0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit f, int m, int sz, bit [31:0] a,
                      bit pr = 0, bit ts = 0, bit mw = 0, bit v = 1, bit clr = 0);
    bit err;
    req_valid = v; cyc_fetch = f; bus_master = 2'(m); acc_size = 2'(sz);
    acc_addr = a; pc_rel = pr; tas_op = ts; mode_wr = mw; hold_clr = clr;
    err = v && ref_err(f, sz, a, pr, ts, mw);
    @(posedge clk);
    if (err && (!e_hv || clr)) begin
      e_ha = a; e_hs = 2'(sz); e_hm = 2'(m); e_hf = f;
    end
    e_hv = err || (e_hv && !clr);
    e_pulse = err;
    @(negedge clk);
    chk(tag, 64'(fault_pulse), 64'(e_pulse), "fault_pulse");
    chk(tag, 64'(hold_valid), 64'(e_hv), "hold_valid");
    if (e_hv) begin
      chk(tag, 64'(hold_addr), 64'(e_ha), "hold_addr");
      chk(tag, 64'({hold_size, hold_master, hold_fetch}), 64'({e_hs, e_hm, e_hf}), "hold_attr");
    end
    req_valid = 0; hold_clr = 0;
  endtask

  task automatic clear_hold();
    step("R11", 0, 0, 0, 32'h0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", 64'(fault_pulse), 0, "fault_pulse in reset");
    chk("R12", 64'(hold_valid), 0, "hold_valid in reset");
    chk("R12", 64'(hold_addr), 0, "hold_addr in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", 64'({hold_valid, hold_size, hold_master, hold_fetch}), 0, "held fields after reset");

    step("R1", 1, 0, 1, 32'h0000_1000);
    step("R1", 1, 0, 1, 32'h0000_1001);
    clear_hold();
    step("R2", 1, 0, 1, 32'hFFFF_FC00);
    clear_hold();
    step("R3", 0, 0, 1, 32'h2000_0003);
    clear_hold();
    step("R3", 0, 1, 2, 32'h2000_0006);
    clear_hold();
    step("R3", 0, 2, 1, 32'h2000_0001);
    clear_hold();
    step("R3", 0, 2, 2, 32'h2000_0004);
    step("R3", 0, 0, 3, 32'h2000_0000);
    clear_hold();
    step("R4", 0, 0, 2, 32'h4000_0000, 1);
    clear_hold();
    step("R4", 0, 0, 2, 32'hC000_0000, 1);
    step("R4", 0, 0, 1, 32'hFFFF_FC00, 1);
    clear_hold();
    step("R4", 0, 0, 2, 32'hFFFE_0010, 1);
    clear_hold();
    step("R4", 0, 0, 2, 32'h2000_0000, 1);
    step("R5", 0, 0, 0, 32'hC000_0010, 0, 1);
    clear_hold();
    step("R5", 0, 0, 0, 32'h6000_0000, 0, 1);
    clear_hold();
    step("R5", 0, 0, 0, 32'h2000_0000, 0, 1);
    step("R6", 0, 0, 0, 32'hFFFF_FC10);
    step("R6", 0, 0, 1, 32'hFFFF_FC12);
    step("R6", 0, 0, 2, 32'hFFFF_FC14);
    step("R6", 0, 0, 0, 32'hFFFF_F100);
    step("R7", 0, 0, 2, 32'hFFFF_FE20);
    clear_hold();
    step("R7", 0, 0, 0, 32'hFFFF_FE21);
    step("R7", 0, 0, 1, 32'hFFFF_FE22);
    step("R8", 0, 0, 0, 32'hFFFF_0000);
    clear_hold();
    step("R8", 0, 0, 0, 32'hFFFF_F0FF);
    clear_hold();
    step("R8", 0, 0, 0, 32'hFFFF_FF80);
    clear_hold();
    step("R8", 0, 0, 2, 32'hFFFF_FF80);
    step("R8", 0, 0, 1, 32'hFFFF_0002);
    step("R9", 1, 0, 1, 32'hFFFF_0001, 0, 0, 1);
    step("R9", 0, 0, 2, 32'hFFFF_FE02, 1, 1, 1);
    step("R10", 0, 0, 2, 32'h2000_0003, 0, 0, 0, 0);
    step("R11", 0, 1, 2, 32'h2000_0002);
    step("R11", 1, 2, 1, 32'h0000_0005);
    step("R11", 0, 0, 2, 32'h2000_0000);
    clear_hold();
    step("R11", 0, 2, 1, 32'h3000_0001);
    step("R11", 1, 0, 1, 32'hFFFF_0000, 0, 0, 0, 1, 1);

    for (int i = 0; i < 400; i++) begin
      bit [31:0] a;
      int pick = $urandom_range(0, 5);
      case (pick)
        0: a = 32'hFFFF_0000 | 32'($urandom_range(0, 16'hFFFF));
        1: a = 32'h4000_0000 | 32'($urandom_range(0, 255));
        2: a = 32'hC000_0000 | 32'($urandom_range(0, 255));
        3: a = 32'hFFFE_0000 | 32'($urandom_range(0, 255));
        4: a = 32'h6000_0000 | 32'($urandom_range(0, 255));
        default: a = $urandom();
      endcase
      step("R10", 1'($urandom_range(0, 1)), $urandom_range(0, 2), $urandom_range(0, 3), a,
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 5) != 0),
           1'($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule